// File: doc/BRIEF.md
# Real-Time Clock Seconds Counter with Alarm

This core keeps wall-clock time as an unsigned 32-bit count of seconds and runs entirely from a slow reference clock of roughly 32 kHz. A reload-programmable prescaler turns the reference clock into a one-second tick. Each tick advances the seconds count, raises a per-second flag, and raises an alarm flag on the tick where the count reaches a programmed alarm value. Software reaches all state through a small word-addressed register port with a combinational read path. A single interrupt output combines the two flags, each gated by its own enable.

Writes are protected, because a stray store must not disturb the time base. Every register write needs a fresh unlock, which is a key value written to a key register. A write is also refused during a short busy window that follows each accepted write, and software polls a ready bit before every store. The status flags are cleared by writing 0 and kept by writing 1. This lets read-modify-write sequences on the control word leave pending events untouched. A general-purpose scratch word is also provided.

Register byte offsets: control 0x00, seconds 0x04, alarm 0x08, reload 0x0C, scratch 0x34, key 0x3C.

Top module: `rtc_core`

## Requirements
- R1: After reset the control word reads 0x80 (only ready set), seconds, alarm and scratch read 0, the reload register reads RELOAD_RST, the key register reads 0 and irq is low.
- R2: A write to any register other than the key register is accepted only while the block is unlocked. Writing exactly 0x0000A55A to the key register (0x3C) unlocks it, and bit 31 of the key register reads 1 while unlocked. A write made while locked changes nothing.
- R3: Each accepted register write locks the block again, so the next write needs a new unlock.
- R4: Ready (control bit 7) reads 0 for exactly BUSY_CYCLES clocks after an accepted write. Writes made during that window are ignored, and they leave the unlock state in place.
- R5: While the counter is enabled (control bit 0), the seconds count advances by one every reload+1 reference clocks. The first advance comes reload+1 clocks after the enabling write. While the counter is disabled, the count holds.
- R6: The per-second flag (control bit 6) sets on every tick.
- R7: Writing 0 to a flag bit (6 or 4) of the control word clears that flag, and writing 1 leaves it unchanged. A flag being set in the same cycle wins over a clear.
- R8: The alarm flag (control bit 4) sets on the tick where the seconds count becomes equal to the alarm register, but only while alarm enable (control bit 2) is 1.
- R9: irq is high exactly when (per-second flag AND its enable, control bit 5) OR (alarm flag AND its enable, control bit 3).
- R10: The seconds, alarm, reload and scratch registers store and read back all 32 bits.
- R11: The seconds count wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, about 32 kHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench measures the exact edge of each seconds advance after enabling. A prescaler that is off by one moves the result by a cycle and is caught. It probes the busy window with a store that is unlocked but too early. A gate that ignored ready, or that relocked on a refused write, would show the wrong scratch value. It writes 1 to a flag that is already pending and expects it to survive, which catches a plain-write flag. It also crosses the 32-bit wrap while the alarm sits at 0 with alarm enable off, which catches a compare that ignores the enable or mishandles the carry.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned OFF_CTRL  = 32'h00;
  localparam int unsigned OFF_SEC   = 32'h04;
  localparam int unsigned OFF_ALM   = 32'h08;
  localparam int unsigned OFF_RLD   = 32'h0C;
  localparam int unsigned OFF_SCR   = 32'h34;
  localparam int unsigned OFF_KEY   = 32'h3C;

  localparam logic [31:0] KEY_VALUE = 32'h0000_A55A;

  localparam int unsigned B_RDY  = 7;
  localparam int unsigned B_HZF  = 6;
  localparam int unsigned B_HZIE = 5;
  localparam int unsigned B_AF   = 4;
  localparam int unsigned B_AIE  = 3;
  localparam int unsigned B_AE   = 2;
  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_UNL  = 31;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] reload,
  output logic         tick
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q >= reload);
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: each tick restarts the period count
  a_r5_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate #(
  parameter int unsigned BUSY_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic key_addr,
  input  logic key_match,
  output logic accept,
  output logic ready,
  output logic unlocked
);
  localparam int unsigned BW = $clog2(BUSY_CYCLES + 1);

  logic [BW-1:0] busy_q, busy_d;
  logic          unl_q, unl_d;
  logic          key_wr;

  always_comb begin
    ready   = (busy_q == '0);
    key_wr  = wr && key_addr && key_match;
    accept  = wr && !key_addr && ready && unl_q;
    unl_d   = unl_q;
    if (accept)      unl_d = 1'b0;
    else if (key_wr) unl_d = 1'b1;
    busy_d  = busy_q;
    if (accept)          busy_d = BW'(BUSY_CYCLES);
    else if (!ready)     busy_d = busy_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      unl_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      unl_q  <= unl_d;
    end
  end

  assign unlocked = unl_q;

  // R3: an accepted write always leaves the block locked
  a_r3_relock: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !unlocked);
  // R4: ready drops right after an accepted write
  a_r4_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BUSY_CYCLES = 3,
  parameter logic [31:0] RELOAD_RST  = 32'd32767
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(OFF_SEC);
  localparam logic [ADDR_W-1:0] A_ALM  = ADDR_W'(OFF_ALM);
  localparam logic [ADDR_W-1:0] A_RLD  = ADDR_W'(OFF_RLD);
  localparam logic [ADDR_W-1:0] A_SCR  = ADDR_W'(OFF_SCR);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFF_KEY);

  logic        accept, ready, unlocked, tick;
  logic [31:0] sec_q, sec_d, alm_q, alm_d, rld_q, rld_d, scr_q, scr_d;
  logic        en_q, en_d, ae_q, ae_d, aie_q, aie_d, hzie_q, hzie_d;
  logic        hzf_q, hzf_d, af_q, af_d;
  logic        wr_ctrl, wr_sec, wr_alm, wr_rld, wr_scr, alarm_hit;
  logic [31:0] sec_inc;

  rtc_wr_gate #(.BUSY_CYCLES(BUSY_CYCLES)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr),
    .key_addr  (bus_addr == A_KEY),
    .key_match (bus_wdata == KEY_VALUE),
    .accept    (accept),
    .ready     (ready),
    .unlocked  (unlocked)
  );

  rtc_prescaler #(.W(32)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (en_q),
    .reload (rld_q),
    .tick   (tick)
  );

  always_comb begin
    wr_ctrl   = accept && (bus_addr == A_CTRL);
    wr_sec    = accept && (bus_addr == A_SEC);
    wr_alm    = accept && (bus_addr == A_ALM);
    wr_rld    = accept && (bus_addr == A_RLD);
    wr_scr    = accept && (bus_addr == A_SCR);
    sec_inc   = sec_q + 32'd1;
    alarm_hit = tick && ae_q && (sec_inc == alm_q);

    sec_d = wr_sec ? bus_wdata : (tick ? sec_inc : sec_q);
    alm_d = wr_alm ? bus_wdata : alm_q;
    rld_d = wr_rld ? bus_wdata : rld_q;
    scr_d = wr_scr ? bus_wdata : scr_q;

    en_d   = wr_ctrl ? bus_wdata[B_EN]   : en_q;
    ae_d   = wr_ctrl ? bus_wdata[B_AE]   : ae_q;
    aie_d  = wr_ctrl ? bus_wdata[B_AIE]  : aie_q;
    hzie_d = wr_ctrl ? bus_wdata[B_HZIE] : hzie_q;
    hzf_d  = tick      | (wr_ctrl ? (hzf_q & bus_wdata[B_HZF]) : hzf_q);
    af_d   = alarm_hit | (wr_ctrl ? (af_q  & bus_wdata[B_AF])  : af_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      alm_q  <= '0;
      rld_q  <= RELOAD_RST;
      scr_q  <= '0;
      en_q   <= 1'b0;
      ae_q   <= 1'b0;
      aie_q  <= 1'b0;
      hzie_q <= 1'b0;
      hzf_q  <= 1'b0;
      af_q   <= 1'b0;
    end else begin
      sec_q  <= sec_d;
      alm_q  <= alm_d;
      rld_q  <= rld_d;
      scr_q  <= scr_d;
      en_q   <= en_d;
      ae_q   <= ae_d;
      aie_q  <= aie_d;
      hzie_q <= hzie_d;
      hzf_q  <= hzf_d;
      af_q   <= af_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_RDY]  = ready;
        bus_rdata[B_HZF]  = hzf_q;
        bus_rdata[B_HZIE] = hzie_q;
        bus_rdata[B_AF]   = af_q;
        bus_rdata[B_AIE]  = aie_q;
        bus_rdata[B_AE]   = ae_q;
        bus_rdata[B_EN]   = en_q;
      end
      A_SEC:   bus_rdata = sec_q;
      A_ALM:   bus_rdata = alm_q;
      A_RLD:   bus_rdata = rld_q;
      A_SCR:   bus_rdata = scr_q;
      A_KEY:   bus_rdata[B_UNL] = unlocked;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = (hzf_q & hzie_q) | (af_q & aie_q);

  // R5: a stopped counter holds its value unless software writes it
  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_sec) |=> $stable(sec_q));
  // R6: every tick leaves the per-second flag set
  a_r6_flag_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> hzf_q);
  // R7: a pending flag survives any cycle without a control write
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (af_q && !wr_ctrl) |=> af_q);
endmodule

// File: tb/sim_rtc_core.sv
`timescale 1ns/1ps
module sim_rtc_core;
  localparam int CLK_P = 30;

  localparam logic [7:0] A_CTRL = 8'h00, A_SEC = 8'h04, A_ALM = 8'h08,
                         A_RLD = 8'h0C, A_SCR = 8'h34, A_KEY = 8'h3C;

  logic        clk, rst_n, bus_wr, irq;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int checks, errors;
  bit done;

  rtc_core u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // {addr, write data, expected readback} for R10
  localparam logic [71:0] VEC [6] = '{
    {A_SCR, 32'h1234_5678, 32'h1234_5678},
    {A_SCR, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {A_ALM, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {A_SEC, 32'h8000_0001, 32'h8000_0001},
    {A_SCR, 32'h0000_0000, 32'h0000_0000},
    {A_RLD, 32'h0000_0004, 32'h0000_0004}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_ready();
    logic [31:0] v;
    rd(A_CTRL, v);
    while (!v[7]) begin
      @(negedge clk);
      rd(A_CTRL, v);
    end
  endtask

  task automatic wr_unl(input logic [7:0] a, input logic [31:0] d);
    wait_ready();
    bus_write(A_KEY, 32'h0000_A55A);
    bus_write(a, d);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, s0;
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h80);
    rd(A_SEC, v);  chk("R1 seconds", v, 0);
    rd(A_ALM, v);  chk("R1 alarm", v, 0);
    rd(A_SCR, v);  chk("R1 scratch", v, 0);
    rd(A_RLD, v);  chk("R1 reload", v, 32'd32767);
    rd(A_KEY, v);  chk("R1 key", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 locked write ignored
    bus_write(A_SCR, 32'h5555_AAAA);
    rd(A_SCR, v); chk("R2 locked write", v, 0);

    // R10 table walk
    foreach (VEC[i]) begin
      wr_unl(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      chk("R10 readback", v, VEC[i][31:0]);
    end

    // R2 / R3 unlock bit and relock
    wait_ready();
    bus_write(A_KEY, 32'h0000_A55A);
    rd(A_KEY, v); chk("R2 unlock bit", v, 32'h8000_0000);
    bus_write(A_SCR, 32'h0000_0011);
    rd(A_KEY, v); chk("R3 relocked", v, 0);
    wait_ready();
    bus_write(A_SCR, 32'h0000_0022);
    rd(A_SCR, v); chk("R3 second write ignored", v, 32'h11);

    // R4 busy window
    wr_unl(A_SCR, 32'h0000_0033);           // accepted at edge A
    rd(A_CTRL, v); chk("R4 ready low", {31'b0, v[7]}, 0);
    bus_write(A_KEY, 32'h0000_A55A);       // edge A+1
    bus_write(A_SCR, 32'h0000_0044);       // edge A+2, busy
    rd(A_SCR, v); chk("R4 busy write ignored", v, 32'h33);
    rd(A_KEY, v); chk("R4 unlock kept", v, 32'h8000_0000);
    rd(A_CTRL, v); chk("R4 ready still low", {31'b0, v[7]}, 0);
    step(1);
    rd(A_CTRL, v); chk("R4 ready back", {31'b0, v[7]}, 1);
    bus_write(A_SCR, 32'h0000_0044);
    rd(A_SCR, v); chk("R4 write after ready", v, 32'h44);

    // R5 / R6 / R9 tick period with reload 4
    wr_unl(A_SEC, 32'd100);
    wr_unl(A_CTRL, 32'h01);                // enable at edge E
    step(4); rd(A_SEC, v); chk("R5 before first tick", v, 100);
    rd(A_CTRL, v); chk("R6 flag clear before tick", {31'b0, v[6]}, 0);
    step(1); rd(A_SEC, v); chk("R5 first tick", v, 101);
    rd(A_CTRL, v); chk("R6 flag set", {31'b0, v[6]}, 1);
    chk("R9 irq masked", {31'b0, irq}, 0);
    step(5); rd(A_SEC, v); chk("R5 second tick", v, 102);
    wr_unl(A_CTRL, 32'h61);                // enable irq, write 1 to flag
    rd(A_CTRL, v); chk("R7 write 1 keeps flag", {31'b0, v[6]}, 1);
    chk("R9 irq per-second", {31'b0, irq}, 1);
    wr_unl(A_CTRL, 32'h40);                // stop, keep flag
    wr_unl(A_CTRL, 32'h00);                // clear flag
    rd(A_CTRL, v); chk("R7 write 0 clears", {31'b0, v[6]}, 0);
    chk("R9 irq low", {31'b0, irq}, 0);
    rd(A_SEC, s0);
    step(20);
    rd(A_SEC, v); chk("R5 hold when disabled", v, s0);

    // R8 alarm
    wr_unl(A_SEC, 32'd200);
    wr_unl(A_ALM, 32'd202);
    wr_unl(A_CTRL, 32'h0D);                // en, ae, aie at edge E
    step(5); rd(A_SEC, v); chk("R8 count 201", v, 201);
    rd(A_CTRL, v); chk("R8 no alarm yet", {31'b0, v[4]}, 0);
    step(4); rd(A_CTRL, v); chk("R8 no alarm before match", {31'b0, v[4]}, 0);
    step(1); rd(A_SEC, v); chk("R8 count 202", v, 202);
    rd(A_CTRL, v); chk("R8 alarm set", {31'b0, v[4]}, 1);
    chk("R9 irq alarm", {31'b0, irq}, 1);
    wr_unl(A_CTRL, 32'h1C);                // stop, keep alarm flag
    chk("R9 irq kept", {31'b0, irq}, 1);
    wr_unl(A_CTRL, 32'h08);                // clear alarm flag
    rd(A_CTRL, v); chk("R7 alarm cleared", {31'b0, v[4]}, 0);
    chk("R9 irq after clear", {31'b0, irq}, 0);

    // R11 wrap, R8 alarm disabled
    wr_unl(A_SEC, 32'hFFFF_FFFF);
    wr_unl(A_ALM, 32'h0);
    wr_unl(A_CTRL, 32'h01);
    step(5); rd(A_SEC, v); chk("R11 wrap", v, 0);
    rd(A_CTRL, v); chk("R8 alarm off no flag", {31'b0, v[4]}, 0);
    wr_unl(A_CTRL, 32'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule